// File: doc/BRIEF.md
# NAND Page Register Column Pointer

This block keeps the byte index into a 528-byte page data register while data moves serially through it. The register has three regions: a first half (columns 0 to 255), a second half (columns 256 to 511) and a 16-byte spare area (columns 512 to 527). The controller picks a region with a decoded area command, then writes a column address byte. The pointer then steps by one on every data-cycle strobe until it reaches the last column.

A pointer command loads the column with the base of the chosen region. An address byte is then added to the base of the currently selected region. In the spare area only the low four bits of that byte count. The second-half selection is good for one access only. The first data cycle after it sends the selection back to the first half, so a later address byte with no new command lands in the first half. The first-half and spare selections stay in force until the next command.

Both outputs are registered. Each one changes on the clock edge that samples the input causing the change.

Top module: `nand_colptr`

## Requirements
- R1: After reset, `col` is 0, `end_of_page` is 0 and the first half is selected: an address byte b loaded with no command gives `col` = b.
- R2: A command with `cmd_code` 2'b00 selects the first half and loads `col` with 0. A following address byte b gives `col` = b.
- R3: A command with `cmd_code` 2'b01 selects the second half and loads `col` with 256. A following address byte b gives `col` = 256 + b.
- R4: A command with `cmd_code` 2'b10 selects the spare area and loads `col` with 512. A following address byte b gives `col` = 512 + b[3:0], and b[7:4] are ignored.
- R5: A data strobe with no command and no address in the same cycle makes `col` one higher on the next edge. This includes the step from 511 to 512.
- R6: `end_of_page` is 1 exactly when `col` is 527. Data strobes seen at 527 leave `col` at 527.
- R7: While the second half is selected, one accepted data strobe returns the selection to the first half. With no strobe in between, repeated address bytes stay in the second half.
- R8: The first-half and spare selections persist across data strobes and address bytes until the next command.
- R9: A command with `cmd_code` 2'b11 (clear) selects the first half and sets `col` to 0.
- R10: In any one cycle a command takes precedence over an address byte, and an address byte takes precedence over a data strobe. A strobe that loses is ignored entirely: no step and no return to the first half.
- R11: Loading a column below 527 while `end_of_page` is 1 clears `end_of_page` on the same edge that loads the column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Decoded pointer command present this cycle |
| cmd_code | input | 2 | 00 first half, 01 second half, 10 spare, 11 clear |
| addr_valid | input | 1 | Column address byte present this cycle |
| addr_byte | input | 8 | Column address byte |
| data_strobe | input | 1 | One data cycle on the register |
| col | output | 10 | Current column index, 0 to 527 |
| end_of_page | output | 1 | High while the column is the last one (527) |

## Verification
Directed sequences load address bytes after each region command. They distinguish the three base offsets and show the four-bit mask in the spare area. Other sequences step across the 511-to-512 boundary and strobe repeatedly at column 527, which separates a pointer that holds from one that wraps or runs past the page. Address bytes are repeated with and without an intervening strobe in the second half to expose when the selection returns to the first half. Collisions of command, address and strobe in the same cycle check precedence. A seeded random mix of all four operations is then compared cycle by cycle against a bench model, which catches interactions the directed cases miss.

// File: rtl/nand_colptr_pkg.sv
package nand_colptr_pkg;
  typedef enum logic [1:0] {
    CMD_FIRST  = 2'b00,
    CMD_SECOND = 2'b01,
    CMD_SPARE  = 2'b10,
    CMD_CLEAR  = 2'b11
  } ptr_cmd_e;

  typedef enum logic [1:0] {
    AREA_FIRST  = 2'b00,
    AREA_SECOND = 2'b01,
    AREA_SPARE  = 2'b10
  } area_e;

  function automatic area_e cmd_to_area(ptr_cmd_e c);
    case (c)
      CMD_SECOND: return AREA_SECOND;
      CMD_SPARE:  return AREA_SPARE;
      default:    return AREA_FIRST;
    endcase
  endfunction
endpackage

// File: rtl/colptr_area.sv
module colptr_area
  import nand_colptr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cmd_valid,
  input  ptr_cmd_e cmd,
  input  logic     addr_valid,
  input  logic     data_strobe,
  output area_e    area
);
  always_ff @(posedge clk) begin
    if (rst) begin
      area <= AREA_FIRST;
    end else if (cmd_valid) begin
      area <= cmd_to_area(cmd);
    end else if (!addr_valid && data_strobe && area == AREA_SECOND) begin
      area <= AREA_FIRST;
    end
  end
endmodule

// File: rtl/colptr_base.sv
module colptr_base
  import nand_colptr_pkg::*;
#(
  parameter int HALF_BYTES  = 256,
  parameter int SPARE_BYTES = 16,
  parameter int ADDR_W      = 8,
  parameter int COL_W       = 10
) (
  input  area_e             area,
  input  logic [ADDR_W-1:0] byte_in,
  output logic [COL_W-1:0]  col
);
  localparam int SPARE_W = (SPARE_BYTES > 1) ? $clog2(SPARE_BYTES) : 1;
  localparam logic [COL_W-1:0] HALF_BASE  = COL_W'(HALF_BYTES);
  localparam logic [COL_W-1:0] SPARE_BASE = COL_W'(2 * HALF_BYTES);

  logic [COL_W-1:0] off_full;
  logic [COL_W-1:0] off_spare;

  assign off_full = COL_W'(byte_in);

  generate
    if (SPARE_W < ADDR_W) begin : g_mask
      assign off_spare = COL_W'(byte_in[SPARE_W-1:0]);
    end else begin : g_nomask
      assign off_spare = COL_W'(byte_in);
    end
  endgenerate

  always_comb begin
    case (area)
      AREA_SECOND: col = HALF_BASE + off_full;
      AREA_SPARE:  col = SPARE_BASE + off_spare;
      default:     col = off_full;
    endcase
  end
endmodule

// File: rtl/colptr_count.sv
module colptr_count #(
  parameter int PAGE_BYTES = 528,
  parameter int COL_W      = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             addr_valid,
  input  logic [COL_W-1:0] addr_col,
  input  logic             data_strobe,
  output logic [COL_W-1:0] col,
  output logic             end_of_page
);
  localparam logic [COL_W-1:0] LAST = COL_W'(PAGE_BYTES - 1);

  logic [COL_W-1:0] nxt;

  always_comb begin
    if (cmd_valid)                      nxt = cmd_col;
    else if (addr_valid)                nxt = addr_col;
    else if (data_strobe && col != LAST) nxt = col + 1'b1;
    else                                nxt = col;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col         <= '0;
      end_of_page <= 1'b0;
    end else begin
      col         <= nxt;
      end_of_page <= (nxt == LAST);
    end
  end
endmodule

// File: rtl/nand_colptr.sv
module nand_colptr
  import nand_colptr_pkg::*;
#(
  parameter int HALF_BYTES  = 256,
  parameter int SPARE_BYTES = 16,
  parameter int ADDR_W      = 8,
  localparam int PAGE_BYTES = 2 * HALF_BYTES + SPARE_BYTES,
  localparam int COL_W      = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_code,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] addr_byte,
  input  logic              data_strobe,
  output logic [COL_W-1:0]  col,
  output logic              end_of_page
);
  ptr_cmd_e         cmd;
  area_e            area_q;
  area_e            cmd_area;
  logic [COL_W-1:0] cmd_col;
  logic [COL_W-1:0] addr_col;

  assign cmd      = ptr_cmd_e'(cmd_code);
  assign cmd_area = cmd_to_area(cmd);

  colptr_area u_area (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd         (cmd),
    .addr_valid  (addr_valid),
    .data_strobe (data_strobe),
    .area        (area_q)
  );

  colptr_base #(
    .HALF_BYTES (HALF_BYTES), .SPARE_BYTES(SPARE_BYTES),
    .ADDR_W     (ADDR_W),     .COL_W      (COL_W)
  ) u_base_cmd (
    .area    (cmd_area),
    .byte_in ('0),
    .col     (cmd_col)
  );

  colptr_base #(
    .HALF_BYTES (HALF_BYTES), .SPARE_BYTES(SPARE_BYTES),
    .ADDR_W     (ADDR_W),     .COL_W      (COL_W)
  ) u_base_addr (
    .area    (area_q),
    .byte_in (addr_byte),
    .col     (addr_col)
  );

  colptr_count #(
    .PAGE_BYTES (PAGE_BYTES),
    .COL_W      (COL_W)
  ) u_count (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_col     (cmd_col),
    .addr_valid  (addr_valid),
    .addr_col    (addr_col),
    .data_strobe (data_strobe),
    .col         (col),
    .end_of_page (end_of_page)
  );
endmodule

// File: rtl/colptr_checker.sv
module colptr_checker #(
  parameter int PAGE_BYTES = 528,
  parameter int HALF_BYTES = 256,
  parameter int COL_W      = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [1:0]       cmd_code,
  input logic             addr_valid,
  input logic             data_strobe,
  input logic [COL_W-1:0] col,
  input logic             end_of_page,
  input logic [1:0]       area
);
  localparam logic [COL_W-1:0] LAST       = COL_W'(PAGE_BYTES - 1);
  localparam logic [COL_W-1:0] SPARE_BASE = COL_W'(2 * HALF_BYTES);

  logic strobe_only;
  assign strobe_only = data_strobe && !cmd_valid && !addr_valid;

  p_col_bound_r6: assert property (@(posedge clk) disable iff (rst)
    col <= LAST);

  p_eop_flag_r6: assert property (@(posedge clk) disable iff (rst)
    end_of_page == (col == LAST));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (end_of_page && strobe_only) |=> (col == LAST));

  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    (strobe_only && col != LAST) |=> (col == COL_W'($past(col) + 1'b1)));

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == 2'b11) |=> (col == '0 && area == 2'b00));

  p_revert_r7: assert property (@(posedge clk) disable iff (rst)
    (area == 2'b01 && strobe_only) |=> (area == 2'b00));

  p_spare_r4: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && !cmd_valid && area == 2'b10) |=> (col >= SPARE_BASE));
endmodule

bind nand_colptr colptr_checker #(
  .PAGE_BYTES (PAGE_BYTES),
  .HALF_BYTES (HALF_BYTES),
  .COL_W      (COL_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_valid   (cmd_valid),
  .cmd_code    (cmd_code),
  .addr_valid  (addr_valid),
  .data_strobe (data_strobe),
  .col         (col),
  .end_of_page (end_of_page),
  .area        (area_q)
);

// File: tb/nand_colptr_test.sv
`timescale 1ns/1ps
module nand_colptr_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_code = 2'b00;
  logic       addr_valid = 1'b0;
  logic [7:0] addr_byte = 8'h00;
  logic       data_strobe = 1'b0;
  logic [9:0] col;
  logic       end_of_page;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int m_area = 0;
  int m_col = 0;

  always #5 clk = ~clk;

  nand_colptr uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .addr_valid(addr_valid), .addr_byte(addr_byte),
    .data_strobe(data_strobe), .col(col), .end_of_page(end_of_page)
  );

  function automatic int area_base(int a);
    return (a == 1) ? 256 : (a == 2) ? 512 : 0;
  endfunction

  task automatic model(bit cv, int cc, bit av, int b, bit ds);
    if (cv) begin
      m_area = (cc == 1) ? 1 : (cc == 2) ? 2 : 0;
      m_col  = area_base(m_area);
    end else if (av) begin
      m_col = area_base(m_area) + ((m_area == 2) ? (b % 16) : b);
    end else if (ds) begin
      if (m_col != 527) m_col++;
      if (m_area == 1) m_area = 0;
    end
  endtask

  task automatic step(bit cv, logic [1:0] cc, bit av, logic [7:0] b, bit ds);
    cmd_valid = cv; cmd_code = cc; addr_valid = av; addr_byte = b; data_strobe = ds;
    model(cv, int'(cc), av, int'(b), ds);
    @(posedge clk); #1;
    cmd_valid = 0; addr_valid = 0; data_strobe = 0;
  endtask

  task automatic check(string tag, int ecol, bit eeop);
    checks++;
    if (int'(col) != ecol || end_of_page != eeop) begin
      errors++;
      $display("FAIL %s: col=%0d eop=%0d expected col=%0d eop=%0d",
               tag, col, end_of_page, ecol, eeop);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1 rst = 0;
    check("R1 reset", 0, 0);
    step(0, 2'b00, 1, 8'd5, 0);   check("R1 first half after reset", 5, 0);

    step(1, 2'b01, 0, 8'd0, 0);   check("R3 second cmd base", 256, 0);
    step(0, 2'b00, 1, 8'h10, 0);  check("R3 second addr", 272, 0);
    step(0, 2'b00, 1, 8'h20, 0);  check("R7 no strobe stays second", 288, 0);
    step(0, 2'b00, 0, 8'd0, 1);   check("R5 step", 289, 0);
    step(0, 2'b00, 1, 8'd3, 0);   check("R7 revert to first", 3, 0);

    step(1, 2'b10, 0, 8'd0, 0);   check("R4 spare cmd base", 512, 0);
    step(0, 2'b00, 1, 8'hFE, 0);  check("R4 spare mask", 526, 0);
    step(0, 2'b00, 0, 8'd0, 1);   check("R6 reach last", 527, 1);
    step(0, 2'b00, 0, 8'd0, 1);   check("R6 hold at last", 527, 1);
    step(0, 2'b00, 1, 8'h01, 0);  check("R11 eop clears", 513, 0);
    step(0, 2'b00, 1, 8'h37, 0);  check("R8 spare persists", 519, 0);

    step(1, 2'b01, 0, 8'd0, 0);
    step(0, 2'b00, 1, 8'hFF, 0);  check("R3 top of second", 511, 0);
    step(0, 2'b00, 0, 8'd0, 1);   check("R5 cross 511 to 512", 512, 0);
    step(0, 2'b00, 1, 8'd0, 0);   check("R7 revert after crossing", 0, 0);

    step(1, 2'b00, 0, 8'd0, 0);
    step(0, 2'b00, 1, 8'd9, 0);
    step(0, 2'b00, 0, 8'd0, 1);
    step(0, 2'b00, 1, 8'd40, 0);  check("R8 first persists", 40, 0);

    step(1, 2'b11, 0, 8'd0, 0);   check("R9 clear", 0, 0);
    step(0, 2'b00, 1, 8'd7, 0);   check("R9 first after clear", 7, 0);

    step(1, 2'b01, 1, 8'd50, 1);  check("R10 cmd wins", 256, 0);
    step(0, 2'b00, 1, 8'd4, 1);   check("R10 addr wins", 260, 0);
    step(0, 2'b00, 1, 8'd1, 0);   check("R10 lost strobe no revert", 257, 0);
    step(1, 2'b00, 0, 8'd0, 0);   check("R2 first cmd", 0, 0);
    step(0, 2'b00, 1, 8'd200, 0); check("R2 first addr", 200, 0);

    for (int i = 0; i < 3000; i++) begin
      int r;
      bit cv, av, ds;
      logic [1:0] cc;
      logic [7:0] b;
      string tag;
      r  = int'($urandom_range(0, 99));
      cc = 2'($urandom_range(0, 3));
      b  = 8'($urandom_range(0, 255));
      cv = (r < 8);
      av = (r >= 8 && r < 20) || (r % 17 == 0);
      ds = (r >= 20) || (r % 5 == 0);
      tag = cv ? "R10 random cmd" : av ? "R3 random addr" : ds ? "R5 random strobe" : "R6 random idle";
      step(cv, cc, av, b, ds);
      check(tag, m_col, (m_col == 527));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule